// File: doc/BRIEF.md
# External Pin Interrupt Trigger Unit

The unit turns six external interrupt pins into interrupt requests for a downstream interrupt controller. Each pin first passes through a two-flop synchroniser. A further flop keeps the previous synchronised sample, so edges can be detected against it. Each channel has a 4-bit trigger code, and all six codes sit packed in one configuration word. Edge codes make a pending flag that stays set until software clears it. Level codes make the pending flag follow the pin while the chosen level is present. Each request output is the channel's pending flag gated by its enable bit.

Software reaches the unit through a 32-bit register port. Reads are combinational from `reg_addr`. A write takes effect at the clock edge on which `reg_wr` is high. Word index `reg_addr[3:2]` selects the register:
- 0: trigger codes
- 1: reserved control word
- 2: pending flags
- 3: enable mask

Each channel runs a three-state machine:
- `CH_QUIET`: nothing pending.
- `CH_LATCHED`: an edge was captured.
- `CH_LEVEL`: the active level is being tracked.

Its transitions:
- **capture**: QUIET or LEVEL to LATCHED on an edge event.
- **track**: QUIET to LEVEL while the active level is present.
- **release**: LEVEL to QUIET when the level goes away.
- **clear**: LATCHED or LEVEL to QUIET when software writes 0 to the pending bit.
- **hold**: any state kept otherwise.

A new event in the same cycle as a clear wins over the clear.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset all pending flags and enable bits are 0, every trigger code is 6 (low level), the configuration word reads 0x0066_6666, and `irq_out` is 0. The synchroniser flops reset to 1, so a pin held high raises nothing.
- R2: With code 1 (rising), a 0-to-1 change of a pin sets the channel's pending bit. The bit is seen after the second clock edge following the edge that first samples the new pin value. A 1-to-0 change sets nothing.
- R3: With code 2 (falling), a 1-to-0 change of the pin sets the pending bit, with the same latency as R2.
- R4: With code 3, both pin transitions set the pending bit.
- R5: With code 5 (high level), the pending bit is 1 while the synchronised pin is 1. It drops, without any clear, once the pin is 0.
- R6: With code 6 (low level), the pending bit is 1 while the synchronised pin is 0. It drops once the pin is 1.
- R7: Codes 0, 4 and 7 to 15 set no pending bit, whatever the pin does.
- R8: The pending register is at byte offset 0x08, bit i for channel i. Writing 0 to a bit clears that flag, and writing 1 has no effect. An edge flag stays set until cleared. A level flag that is cleared comes back one cycle later if the level persists. An event in the clear cycle keeps the flag set.
- R9: The enable register is at byte offset 0x0C, bit i for channel i. `irq_out[i]` is 1 exactly when pending bit i and enable bit i are both 1.
- R10: The configuration register is at byte offset 0x00, with channel i's code in bits [4i+3:4i] and bits 31:24 reading 0. Offset 0x04 always reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 6 | Asynchronous external interrupt pins |
| reg_addr | input | 4 | Byte address of register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 6 | Gated interrupt requests |

## Verification
Directed pin sequences give each channel its own trigger code and toggle one pin at a time. This separates rising, falling and both-edge capture from level tracking, and shows that the unused codes stay silent. Partial clears with mixed ones and zeros check that only the zero bits clear. A clear issued while a low level is still present checks that the flag comes back. A constrained random phase then flips pins at random. It also writes random codes (unused ones included), random clear masks and random enable masks, and so reaches clear-versus-event collisions and mid-flight mode changes. Each cycle, that phase compares requests and read data with a cycle model in the bench.

// File: rtl/eit_pkg.sv
package eit_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] TRIG_NONE = 4'd0;
    localparam logic [CODE_W-1:0] TRIG_RISE = 4'd1;
    localparam logic [CODE_W-1:0] TRIG_FALL = 4'd2;
    localparam logic [CODE_W-1:0] TRIG_BOTH = 4'd3;
    localparam logic [CODE_W-1:0] TRIG_HIGH = 4'd5;
    localparam logic [CODE_W-1:0] TRIG_LOW  = 4'd6;

    localparam logic [CODE_W-1:0] TRIG_RESET = TRIG_LOW;

    localparam logic [1:0] IDX_MODE = 2'd0;
    localparam logic [1:0] IDX_AUX  = 2'd1;
    localparam logic [1:0] IDX_PEND = 2'd2;
    localparam logic [1:0] IDX_EN   = 2'd3;

    typedef enum logic [1:0] {
        CH_QUIET   = 2'd0,
        CH_LATCHED = 2'd1,
        CH_LEVEL   = 2'd2
    } ch_state_t;

endpackage

// File: rtl/eit_pin_sync.sv
module eit_pin_sync #(
    parameter int NUM_CH = 6,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_raw,
    output logic [NUM_CH-1:0] pin_lvl,
    output logic [NUM_CH-1:0] pin_rise,
    output logic [NUM_CH-1:0] pin_fall
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [DEPTH-1:0] shift_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shift_q <= '1;
            else        shift_q <= {shift_q[DEPTH-2:0], pin_raw[g]};
        end

        assign pin_lvl[g]  = shift_q[STAGES-1];
        assign pin_rise[g] = shift_q[STAGES-1] & ~shift_q[STAGES];
        assign pin_fall[g] = ~shift_q[STAGES-1] & shift_q[STAGES];
    end

endmodule

// File: rtl/eit_channel.sv
module eit_channel
    import eit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mode,
    input  logic              lvl,
    input  logic              rise,
    input  logic              fall,
    input  logic              clr_req,
    output logic              pending
);
    ch_state_t state_q, state_d;
    logic      edge_ev;
    logic      lvl_act;
    logic      mode_unused;

    // trigger-code decode
    always_comb begin
        edge_ev = 1'b0;
        lvl_act = 1'b0;
        unique case (mode)
            TRIG_RISE: edge_ev = rise;
            TRIG_FALL: edge_ev = fall;
            TRIG_BOTH: edge_ev = rise | fall;
            TRIG_HIGH: lvl_act = lvl;
            TRIG_LOW:  lvl_act = ~lvl;
            default: begin
                edge_ev = 1'b0;
                lvl_act = 1'b0;
            end
        endcase
    end

    assign mode_unused = (mode == 4'd0) || (mode == 4'd4) || (mode >= 4'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_QUIET;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_QUIET: begin
                if (edge_ev)      state_d = CH_LATCHED;   // capture
                else if (lvl_act) state_d = CH_LEVEL;     // track
            end
            CH_LATCHED: begin
                if (edge_ev)      state_d = CH_LATCHED;   // hold
                else if (clr_req) state_d = CH_QUIET;     // clear
            end
            CH_LEVEL: begin
                if (edge_ev)                  state_d = CH_LATCHED; // capture
                else if (clr_req || !lvl_act) state_d = CH_QUIET;   // clear / release
            end
            default: state_d = CH_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        pending = (state_q != CH_QUIET);
    end

    assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_LATCHED && !clr_req) |=> (state_q == CH_LATCHED));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_QUIET && clr_req && !edge_ev) |=> (state_q == CH_QUIET));

    assert_level_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_LEVEL && !edge_ev && !lvl_act) |=> (state_q == CH_QUIET));

    assert_idle_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_QUIET && mode_unused) |=> (state_q == CH_QUIET));

endmodule

// File: rtl/eit_regs.sv
module eit_regs
    import eit_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               reg_addr,
    input  logic                     reg_wr,
    input  logic [31:0]              reg_wdata,
    input  logic [NUM_CH-1:0]        pend_vec,
    output logic [31:0]              reg_rdata,
    output logic [NUM_CH*CODE_W-1:0] mode_flat,
    output logic [NUM_CH-1:0]        enable,
    output logic [NUM_CH-1:0]        clr_vec
);
    localparam int MODE_BITS = NUM_CH * CODE_W;

    logic [1:0] idx;
    assign idx = reg_addr[3:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_flat <= {NUM_CH{TRIG_RESET}};
            enable    <= '0;
        end else if (reg_wr) begin
            if (idx == IDX_MODE) mode_flat <= reg_wdata[MODE_BITS-1:0];
            if (idx == IDX_EN)   enable    <= reg_wdata[NUM_CH-1:0];
        end
    end

    assign clr_vec = (reg_wr && idx == IDX_PEND) ? ~reg_wdata[NUM_CH-1:0] : '0;

    always_comb begin
        reg_rdata = '0;
        unique case (idx)
            IDX_MODE: reg_rdata[MODE_BITS-1:0] = mode_flat;
            IDX_AUX:  reg_rdata = '0;
            IDX_PEND: reg_rdata[NUM_CH-1:0] = pend_vec;
            IDX_EN:   reg_rdata[NUM_CH-1:0] = enable;
            default:  reg_rdata = '0;
        endcase
    end

    assert_mode_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && idx == IDX_MODE) |=> (mode_flat == $past(reg_wdata[MODE_BITS-1:0])));

    assert_aux_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && idx == IDX_AUX) |=> ($stable(mode_flat) && $stable(enable)));

    assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && idx == IDX_EN) |=> (enable == $past(reg_wdata[NUM_CH-1:0])));

endmodule

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger
    import eit_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NUM_CH-1:0] irq_out
);
    logic [NUM_CH-1:0]        lvl, rise, fall;
    logic [NUM_CH-1:0]        pend_vec, enable, clr_vec;
    logic [NUM_CH*CODE_W-1:0] mode_flat;

    eit_pin_sync #(.NUM_CH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_lvl  (lvl),
        .pin_rise (rise),
        .pin_fall (fall)
    );

    eit_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .pend_vec  (pend_vec),
        .reg_rdata (reg_rdata),
        .mode_flat (mode_flat),
        .enable    (enable),
        .clr_vec   (clr_vec)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        eit_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode    (mode_flat[c*CODE_W +: CODE_W]),
            .lvl     (lvl[c]),
            .rise    (rise[c]),
            .fall    (fall[c]),
            .clr_req (clr_vec[c]),
            .pending (pend_vec[c])
        );
    end

    assign irq_out = pend_vec & enable;

endmodule

// File: tb/ext_irq_trigger_bench.sv
module ext_irq_trigger_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pin_in = 6'h3F;
    logic [3:0]  reg_addr = 4'h0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model
    logic [2:0]  m_sh [NCH];
    int          m_st [NCH];   // 0 none, 1 edge-held, 2 level-tracked
    logic [23:0] m_mode;
    logic [5:0]  m_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_trigger u_ext_irq_trigger (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    function automatic logic [5:0] m_pend();
        logic [5:0] p;
        for (int c = 0; c < NCH; c++) p[c] = (m_st[c] != 0);
        return p;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return {8'h00, m_mode};
            2'd2:    return {26'b0, m_pend()};
            2'd3:    return {26'b0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin m_sh[c] = 3'b111; m_st[c] = 0; end
            m_mode = 24'h666666;
            m_en   = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                logic s2, s3, rs, fl, ev, la, clr;
                logic [3:0] md;
                s2 = m_sh[c][1]; s3 = m_sh[c][2];
                md = m_mode[4*c +: 4];
                rs = s2 & ~s3; fl = ~s2 & s3;
                ev = (md == 1 && rs) || (md == 2 && fl) || (md == 3 && (rs || fl));
                la = (md == 5 && s2) || (md == 6 && !s2);
                clr = reg_wr && reg_addr[3:2] == 2'd2 && !reg_wdata[c];
                case (m_st[c])
                    0: if (ev) m_st[c] = 1; else if (la) m_st[c] = 2;
                    1: if (!ev && clr) m_st[c] = 0;
                    default: if (ev) m_st[c] = 1; else if (clr || !la) m_st[c] = 0;
                endcase
                m_sh[c] = {m_sh[c][1:0], pin_in[c]};
            end
            if (reg_wr && reg_addr[3:2] == 2'd0) m_mode = reg_wdata[23:0];
            if (reg_wr && reg_addr[3:2] == 2'd3) m_en = reg_wdata[5:0];
        end
    end

    task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one cycle: wait for falling edge, compare against model, release write strobe
    task automatic tick(input string req);
        @(negedge clk);
        check_eq({26'b0, irq_out}, {26'b0, m_pend() & m_en}, {req, " irq (R9)"});
        check_eq(reg_rdata, m_read(reg_addr), {req, " read"});
        reg_wr = 1'b0;
    endtask

    task automatic wait_n(input int n, input string req);
        repeat (n) tick(req);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(req);
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        tick(req);
        check_eq(reg_rdata, exp, req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));

        // R1 reset state
        repeat (3) @(negedge clk);
        reg_addr = 4'h0; #1;
        check_eq(reg_rdata, 32'h0066_6666, "R1 mode reset");
        reg_addr = 4'h8; #1;
        check_eq(reg_rdata, 32'h0, "R1 pending reset");
        reg_addr = 4'hC; #1;
        check_eq(reg_rdata, 32'h0, "R1 enable reset");
        check_eq({26'b0, irq_out}, 32'h0, "R1 irq reset");
        rst_n = 1'b1;
        wait_n(4, "R1");
        expect_reg(4'h8, 32'h0, "R1 pins high no pend");

        wr(4'hC, 32'h3F, "R9");
        wr(4'h0, 32'h0046_5321, "R10");
        wr(4'h8, 32'h0, "R8");
        wait_n(4, "R5");
        expect_reg(4'h8, 32'h08, "R5 high level pending");
        check_eq({26'b0, irq_out}, 32'h08, "R9 irq follows pending");
        pin_in[3] = 1'b0; wait_n(4, "R5");
        expect_reg(4'h8, 32'h00, "R5 level released");

        pin_in[0] = 1'b0; wait_n(4, "R2");
        expect_reg(4'h8, 32'h00, "R2 falling ignored");
        pin_in[0] = 1'b1; wait_n(4, "R2");
        expect_reg(4'h8, 32'h01, "R2 rising captured");

        pin_in[1] = 1'b0; wait_n(4, "R3");
        expect_reg(4'h8, 32'h03, "R3 falling captured");

        pin_in[2] = 1'b0; wait_n(4, "R4");
        expect_reg(4'h8, 32'h07, "R4 fall in both mode");
        wr(4'h8, 32'h3B, "R8");
        expect_reg(4'h8, 32'h03, "R8 partial clear");
        pin_in[2] = 1'b1; wait_n(4, "R4");
        expect_reg(4'h8, 32'h07, "R4 rise in both mode");

        pin_in[4] = 1'b0; wait_n(4, "R6");
        expect_reg(4'h8, 32'h17, "R6 low level pending");
        wr(4'h8, 32'h0, "R8");
        wait_n(4, "R8");
        expect_reg(4'h8, 32'h10, "R8 level reasserts after clear");
        pin_in[4] = 1'b1; wait_n(4, "R6");
        expect_reg(4'h8, 32'h00, "R6 level released");

        pin_in[5] = 1'b0; wait_n(4, "R7");
        pin_in[5] = 1'b1; wait_n(4, "R7");
        expect_reg(4'h8, 32'h00, "R7 code 4 silent");
        wr(4'h0, 32'h0046_532F, "R7");
        pin_in[0] = 1'b0; wait_n(4, "R7");
        pin_in[0] = 1'b1; wait_n(4, "R7");
        expect_reg(4'h8, 32'h00, "R7 code 15 silent");

        wr(4'h0, 32'h0046_5321, "R2");
        pin_in[0] = 1'b0; wait_n(4, "R2");
        pin_in[0] = 1'b1; wait_n(4, "R2");
        wr(4'hC, 32'h3E, "R9");
        expect_reg(4'h8, 32'h01, "R9 pending while masked");
        check_eq({26'b0, irq_out}, 32'h00, "R9 masked irq");
        wr(4'hC, 32'h3F, "R9");
        check_eq({26'b0, irq_out}, 32'h01, "R9 unmasked irq");

        wr(4'h4, 32'hFFFF_FFFF, "R10");
        expect_reg(4'h4, 32'h0, "R10 reserved reads zero");
        expect_reg(4'h0, 32'h0046_5321, "R10 mode untouched");
        expect_reg(4'hC, 32'h3F, "R10 enable untouched");
        expect_reg(4'h8, 32'h01, "R10 pending untouched");

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            for (int c = 0; c < NCH; c++)
                if (($urandom % 8) == 0) pin_in[c] = ~pin_in[c];
            r = $urandom % 16;
            reg_addr = 4'($urandom % 4) << 2;
            if (r == 0) begin
                reg_addr = 4'h0; reg_wdata = $urandom; reg_wr = 1'b1;
            end else if (r == 1 || r == 2) begin
                reg_addr = 4'h8;
                reg_wdata = (r == 1) ? ~(32'h1 << ($urandom % 6)) : $urandom;
                reg_wr = 1'b1;
            end else if (r == 3) begin
                reg_addr = 4'hC; reg_wdata = $urandom; reg_wr = 1'b1;
            end else if (r == 4) begin
                reg_addr = 4'h4; reg_wdata = $urandom; reg_wr = 1'b1;
            end
            tick("R8 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule